// File: doc/BRIEF.md
# Status byte service request logic

This block is the reporting core of an instrument's status model. It presents an 8-bit status byte whose summary bits follow summary-message levels from upstream event logic. It also holds a host-written enable mask that chooses which summary bits may raise a service request. From these it forms the bit-6 request logic and drives a service-request output.

The byte can be read in two ways. The direct query value `query_data` is a pure read. Its bit 6 is the live master summary: the OR of the summary bits that are enabled. Reading it changes nothing.

The poll value `poll_data` carries a latched request flag in bit 6. When a one-cycle `poll_req` strobe is taken at a clock edge, the flag is cleared. A one-cycle `clr_stat` strobe clears the status byte. Each summary bit then reads 0 until its message input returns to 0 and it tracks its input again. The parameter `CLR_MAV` selects whether the message-available bit, bit 4, takes part in this clearing. All pins are plain level or strobe controls. There is no handshake.

Top module: `stb_srq_core`

## Requirements
- R1: Status bits 0, 2, 3, 4, 5 and 7 of `query_data` and `poll_data` equal the current level of the same bits of `sum_msg`, with no latching. Bit 1 always reads 0. Bit 6 of `sum_msg` has no effect.
- R2: When a summary-message input falls to 0, its status bit reads 0 in that same cycle, with no clock edge in between.
- R3: `query_data[6]` is the OR, over bits 0, 2, 3, 4, 5 and 7, of the summary bit ANDed with the matching bit of the enable mask. An enable bit of 0 masks its summary bit.
- R4: Reading `query_data` clears nothing. While `poll_req` and `clr_stat` stay low and the inputs stay constant, the status byte and `srq_o` stay constant.
- R5: `poll_data` is the status byte with bit 6 replaced by the request flag. A `poll_req` high at a clock edge clears the flag at that edge, unless R11 applies.
- R6: A `clr_stat` high at a clock edge clears the request flag and forces every status bit to read 0 from that edge on. A bit is released once its input has been seen at 0 on a clock edge, and it follows its input again after that. Bit 4 takes part only when `CLR_MAV` is 1, which is the default.
- R7: While `rst_n` is low, all status bits, the enable mask and the flag are 0. After reset, each summary bit stays 0 until its input has been seen at 0.
- R8: A clock edge with `sre_wr` high stores `sre_wdata & 8'hBD` into the enable mask. Bits 6 and 1 are ignored and always read 0 on `sre_rdata`.
- R9: The request flag is set at the edge after the master summary rises from 0 to 1. Once a poll has cleared it, the flag is not set again while the master summary stays at 1.
- R10: `srq_o` is high exactly while the request flag is set. It drops right after the edge that takes a poll.
- R11: If `poll_req` is high in the same cycle as a new rise of the master summary, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sum_msg | input | 8 | Summary-message levels; bits 1 and 6 are unused |
| sre_wr | input | 1 | Enable-mask write strobe |
| sre_wdata | input | 8 | Enable-mask write value |
| sre_rdata | output | 8 | Enable-mask readback |
| clr_stat | input | 1 | Clear-status strobe |
| poll_req | input | 1 | Serial-poll strobe; clears the request flag at the edge |
| query_data | output | 8 | Direct query value; bit 6 is the master summary |
| poll_data | output | 8 | Poll value; bit 6 is the request flag |
| srq_o | output | 1 | Service-request output, active high |

## Verification
The hardest case to reach is a poll that lands in the same cycle as a fresh rise of the master summary. To reach it, the flag must already be set and the summary must fall and rise again without an intervening poll. The bench first sets the flag, then drops the enabled message for exactly one cycle, and then raises it again in the cycle that carries the poll strobe. A second hard case is the hold after clear-status. The bench keeps a message high across the clear and checks that the bit stays at 0 until that input has been low for one edge.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int unsigned STB_W   = 8;
  localparam int unsigned RQS_BIT = 6;
  localparam int unsigned MAV_BIT = 4;
  // bits that carry summary messages: 7,5,4,3,2,0
  localparam logic [STB_W-1:0] SUM_MASK = 8'hBD;
endpackage

// File: rtl/stb_summary.sv
module stb_summary
  import stb_pkg::*;
#(
  parameter bit CLR_MAV = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STB_W-1:0] sum_msg,
  input  logic             clr_stat,
  output logic [STB_W-1:0] sbits
);
  localparam logic [STB_W-1:0] MAV_ONE  = STB_W'(1) << MAV_BIT;
  localparam logic [STB_W-1:0] CLR_MASK = CLR_MAV ? SUM_MASK : (SUM_MASK & ~MAV_ONE);
  localparam logic [STB_W-1:0] RST_HOLD = SUM_MASK;

  logic [STB_W-1:0] hold_q;

  genvar b;
  generate
    for (b = 0; b < STB_W; b++) begin : g_bit
      if (SUM_MASK[b]) begin : g_sum
        always_ff @(posedge clk) begin
          if (!rst_n)
            hold_q[b] <= RST_HOLD[b];
          else if (clr_stat && CLR_MASK[b])
            hold_q[b] <= 1'b1;
          else if (!sum_msg[b])
            hold_q[b] <= 1'b0;
        end
        assign sbits[b] = rst_n & sum_msg[b] & ~hold_q[b];
      end else begin : g_none
        always_ff @(posedge clk) hold_q[b] <= 1'b0;
        assign sbits[b] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/stb_sre_reg.sv
module stb_sre_reg
  import stb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [STB_W-1:0] wdata,
  output logic [STB_W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)  mask <= '0;
    else if (wr) mask <= wdata & SUM_MASK;
  end
endmodule

// File: rtl/stb_rqs.sv
module stb_rqs
  import stb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STB_W-1:0] sbits,
  input  logic [STB_W-1:0] mask,
  input  logic             poll_req,
  input  logic             clr_stat,
  output logic             mss,
  output logic             rise,
  output logic             flag
);
  logic mss_prev_q;

  assign mss  = |(sbits & mask & SUM_MASK);
  assign rise = mss & ~mss_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mss_prev_q <= 1'b0;
      flag       <= 1'b0;
    end else begin
      mss_prev_q <= mss;
      if (clr_stat)      flag <= 1'b0;
      else if (rise)     flag <= 1'b1;
      else if (poll_req) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/stb_srq_core.sv
module stb_srq_core
  import stb_pkg::*;
#(
  parameter bit CLR_MAV = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STB_W-1:0] sum_msg,
  input  logic             sre_wr,
  input  logic [STB_W-1:0] sre_wdata,
  output logic [STB_W-1:0] sre_rdata,
  input  logic             clr_stat,
  input  logic             poll_req,
  output logic [STB_W-1:0] query_data,
  output logic [STB_W-1:0] poll_data,
  output logic             srq_o
);
  logic [STB_W-1:0] sbits;
  logic             mss, rise, flag;

  stb_summary #(.CLR_MAV(CLR_MAV)) u_sum (
    .clk(clk), .rst_n(rst_n), .sum_msg(sum_msg), .clr_stat(clr_stat), .sbits(sbits)
  );

  stb_sre_reg u_sre (
    .clk(clk), .rst_n(rst_n), .wr(sre_wr), .wdata(sre_wdata), .mask(sre_rdata)
  );

  stb_rqs u_rqs (
    .clk(clk), .rst_n(rst_n), .sbits(sbits), .mask(sre_rdata),
    .poll_req(poll_req), .clr_stat(clr_stat), .mss(mss), .rise(rise), .flag(flag)
  );

  always_comb begin
    query_data          = sbits;
    query_data[RQS_BIT] = mss;
    poll_data           = sbits;
    poll_data[RQS_BIT]  = flag;
  end

  assign srq_o = flag;
endmodule

// File: rtl/stb_srq_chk.sv
module stb_srq_chk
  import stb_pkg::*;
#(
  parameter bit CLR_MAV = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [STB_W-1:0] sum_msg,
  input logic [STB_W-1:0] sre_rdata,
  input logic             clr_stat,
  input logic             poll_req,
  input logic [STB_W-1:0] query_data,
  input logic [STB_W-1:0] poll_data,
  input logic             srq_o,
  input logic             rise
);
  localparam logic [STB_W-1:0] CHK_CLR =
    CLR_MAV ? SUM_MASK : (SUM_MASK & ~(STB_W'(1) << MAV_BIT));
  localparam logic [STB_W-1:0] LOW_MASK = SUM_MASK & ~(STB_W'(1) << RQS_BIT);

  AST_SUM_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((query_data & LOW_MASK & ~sum_msg) == '0)) else $error("AST_SUM_NO_LATCH"); // R1

  AST_MSS_OR: assert property (@(posedge clk) disable iff (!rst_n)
    query_data[RQS_BIT] == |(query_data & sre_rdata & LOW_MASK)) else $error("AST_MSS_OR"); // R3

  AST_POLL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_req && !rise) |=> !srq_o) else $error("AST_POLL_CLEARS"); // R5

  AST_CLR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stat |=> (!srq_o && ((query_data & CHK_CLR) == '0))) else $error("AST_CLR_STATUS"); // R6

  AST_SRE_B6_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sre_rdata & ~SUM_MASK) == '0) else $error("AST_SRE_B6_ZERO"); // R8

  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !clr_stat) |=> srq_o) else $error("AST_RISE_SETS"); // R11

  AST_SRQ_IS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    poll_data[RQS_BIT] == srq_o) else $error("AST_SRQ_IS_FLAG"); // R10
endmodule

bind stb_srq_core stb_srq_chk #(.CLR_MAV(CLR_MAV)) u_chk (
  .clk(clk), .rst_n(rst_n), .sum_msg(sum_msg), .sre_rdata(sre_rdata),
  .clr_stat(clr_stat), .poll_req(poll_req), .query_data(query_data),
  .poll_data(poll_data), .srq_o(srq_o), .rise(rise)
);

// File: tb/stb_srq_core_tb.sv
module stb_srq_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sum_msg = 8'h00;
  logic       sre_wr = 1'b0;
  logic [7:0] sre_wdata = 8'h00;
  logic [7:0] sre_rdata;
  logic       clr_stat = 1'b0;
  logic       poll_req = 1'b0;
  logic [7:0] query_data, poll_data;
  logic       srq_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  stb_srq_core u_dut (
    .clk(clk), .rst_n(rst_n), .sum_msg(sum_msg), .sre_wr(sre_wr), .sre_wdata(sre_wdata),
    .sre_rdata(sre_rdata), .clr_stat(clr_stat), .poll_req(poll_req),
    .query_data(query_data), .poll_data(poll_data), .srq_o(srq_o)
  );

  // {sre value, sum_msg, expected query_data}
  localparam logic [23:0] VEC [6] = '{
    {8'h01, 8'h01, 8'h41},
    {8'h01, 8'hFE, 8'hBC},
    {8'h80, 8'h80, 8'hC0},
    {8'h10, 8'h52, 8'h50},
    {8'hFF, 8'h42, 8'h00},
    {8'h24, 8'h24, 8'h64}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // advance one edge; return at negedge plus settle time
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic wr_sre(input logic [7:0] v);
    sre_wr = 1'b1; sre_wdata = v;
    step();
    sre_wr = 1'b0;
  endtask

  task automatic do_poll();
    poll_req = 1'b1;
    step();
    poll_req = 1'b0;
  endtask

  initial begin
    #200000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R7: reset with messages high
    sum_msg = 8'hFF;
    step(3);
    check("R7 query in reset", query_data, 8'h00);
    check("R7 poll in reset", poll_data, 8'h00);
    check("R7 sre in reset", sre_rdata, 8'h00);
    check("R7 srq in reset", {7'd0, srq_o}, 8'h00);
    rst_n = 1'b1;
    step(2);
    check("R7 hold after reset", query_data, 8'h00);
    sum_msg = 8'h00;
    step(2);

    // R8: enable mask ignores bits 6 and 1
    wr_sre(8'hFF);
    check("R8 sre readback", sre_rdata, 8'hBD);

    // R1 R3: vector table
    foreach (VEC[i]) begin
      wr_sre(VEC[i][23:16]);
      sum_msg = VEC[i][15:8];
      #1;
      check($sformatf("R1 R3 vector %0d", i), query_data, VEC[i][7:0]);
    end
    sum_msg = 8'h00;
    step(2);
    do_poll();
    check("R5 flag clear before directed", {7'd0, srq_o}, 8'h00);

    // R9 R10: rise sets flag at next edge
    wr_sre(8'h01);
    sum_msg = 8'h01;
    #1;
    check("R3 live mss", query_data, 8'h41);
    check("R10 srq before edge", {7'd0, srq_o}, 8'h00);
    step();
    check("R10 srq after rise", {7'd0, srq_o}, 8'h01);
    check("R5 poll value", poll_data, 8'h41);
    // R4: query reads clear nothing
    step(3);
    check("R4 query stable", query_data, 8'h41);
    check("R4 srq stable", {7'd0, srq_o}, 8'h01);
    // R5: poll clears flag
    do_poll();
    check("R5 srq after poll", {7'd0, srq_o}, 8'h00);
    check("R5 poll bit6 cleared", poll_data, 8'h01);
    check("R4 query after poll", query_data, 8'h41);
    // R9: no re-set while mss stays high
    step(3);
    check("R9 no re-set", {7'd0, srq_o}, 8'h00);
    // R2: falling input clears bit same cycle
    sum_msg = 8'h00;
    #1;
    check("R2 same-cycle drop", query_data, 8'h00);
    step();

    // R11: poll coincides with new rise
    sum_msg = 8'h01;
    step();
    check("R11 flag set", {7'd0, srq_o}, 8'h01);
    sum_msg = 8'h00;
    step();
    sum_msg = 8'h01; poll_req = 1'b1;
    step();
    poll_req = 1'b0;
    check("R11 flag kept", {7'd0, srq_o}, 8'h01);
    do_poll();
    check("R11 later poll clears", {7'd0, srq_o}, 8'h00);

    // R6: clear-status
    sum_msg = 8'h00;
    step();
    sum_msg = 8'h11;
    step();
    check("R6 pre-clear srq", {7'd0, srq_o}, 8'h01);
    clr_stat = 1'b1;
    step();
    clr_stat = 1'b0;
    check("R6 bits cleared (MAV too)", query_data, 8'h00);
    check("R6 flag cleared", {7'd0, srq_o}, 8'h00);
    step(2);
    check("R6 hold while input high", query_data, 8'h00);
    sum_msg = 8'h00;
    step();
    sum_msg = 8'h11;
    #1;
    check("R6 released after low", query_data, 8'h51);
    step();
    check("R6 new request", {7'd0, srq_o}, 8'h01);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule